// File: doc/BRIEF.md
# Two-Cycle Port I/O Sequencer

This block runs the port-mapped I/O bus of a small 8-bit controller. A transfer always takes exactly two clock cycles. A one-cycle start request carries four things: a direction, a port address, the data to send, and a destination register index. The port address comes either from an immediate field or from a register operand. The block puts the address on `port_id` and holds it there for both cycles of the transfer. On an output transfer it holds the source byte on `out_port` for the same two cycles. It raises a single strobe in the second cycle: `write_strobe` for an output and `read_strobe` for an input.

During the second cycle of an input transfer, the block presents `in_port` to the register file through a write port. The register file captures the byte at the same rising edge where the peripheral sees `read_strobe`. Peripherals latch `out_port` at the edge where `write_strobe` is high. Address decoding and the peripherals themselves sit outside this block.

Top module: `io_bus_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, both strobes, `busy` and `rf_we` are low, and `port_id` and `out_port` are zero.
- R2: A start accepted at a rising edge (`start` high, `busy` low) makes `busy` high for exactly the next two cycles. `port_id` equals `reg_addr` when `addr_from_reg` is 1 and `imm_addr` when it is 0, and holds that value in both cycles.
- R3: For an output transfer (`is_output` = 1), `out_port` carries the `src_data` sampled with the start, for both cycles.
- R4: `write_strobe` is high only in the second cycle of an output transfer, for exactly one cycle, and `read_strobe` stays low throughout an output transfer.
- R5: `read_strobe` is high only in the second cycle of an input transfer (`is_output` = 0), for exactly one cycle. In that same cycle `rf_we` is high, `rf_wdata` equals `in_port`, and `rf_widx` equals the `dst_idx` sampled with the start. `write_strobe` stays low throughout an input transfer.
- R6: A start request that arrives while `busy` is high is ignored. It does not change `port_id`, `out_port` or `rf_widx`, and it does not lengthen the transfer.
- R7: Outside a transfer, `port_id` and `out_port` keep their last values and both strobes are low. An input transfer leaves `out_port` unchanged.
- R8: Every port address from 0x00 to 0xFF reaches `port_id` unaltered, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a transfer (sampled when not busy) |
| is_output | input | 1 | 1 = output transfer, 0 = input transfer |
| addr_from_reg | input | 1 | 1 = take address from `reg_addr`, 0 = from `imm_addr` |
| imm_addr | input | ADDR_W | Immediate port address |
| reg_addr | input | ADDR_W | Register-supplied port address |
| src_data | input | DATA_W | Byte to send on an output transfer |
| dst_idx | input | RIDX_W | Destination register index for an input transfer |
| in_port | input | DATA_W | Data returned by the addressed peripheral |
| port_id | output | ADDR_W | Port address on the bus |
| out_port | output | DATA_W | Output data on the bus |
| read_strobe | output | 1 | Input transfer strobe, second cycle |
| write_strobe | output | 1 | Output transfer strobe, second cycle |
| busy | output | 1 | High across both cycles of a transfer |
| rf_we | output | 1 | Register file write enable for input data |
| rf_widx | output | RIDX_W | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The bench builds the sequencer with its default widths: an 8-bit address, an 8-bit data path and a 4-bit register index. With these widths the two extreme port addresses, 0x00 and 0xFF, can be driven directly, so both ends of the address space are exercised through the immediate and the register address paths. The 4-bit index lets the bench aim input data at the first and the last register, and all-ones and all-zeros data patterns expose stuck bits on the data paths. Start requests held high through a whole transfer, with different operands, show whether a request raised while busy is really ignored.

// File: rtl/io_bus_sequencer.sv
module io_bus_sequencer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_output,
  input  logic              addr_from_reg,
  input  logic [ADDR_W-1:0] imm_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] src_data,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [DATA_W-1:0] in_port,
  output logic [ADDR_W-1:0] port_id,
  output logic [DATA_W-1:0] out_port,
  output logic              read_strobe,
  output logic              write_strobe,
  output logic              busy,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_widx,
  output logic [DATA_W-1:0] rf_wdata
);

  logic phase1, phase2, dir_out;
  logic accept;

  assign busy   = phase1 | phase2;
  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase1   <= 1'b0;
      phase2   <= 1'b0;
      dir_out  <= 1'b0;
      port_id  <= '0;
      out_port <= '0;
      rf_widx  <= '0;
    end else begin
      phase1 <= accept;
      phase2 <= phase1;
      if (accept) begin
        dir_out <= is_output;
        port_id <= addr_from_reg ? reg_addr : imm_addr;
        rf_widx <= dst_idx;
        if (is_output) out_port <= src_data;
      end
    end
  end

  assign write_strobe = phase2 & dir_out;
  assign read_strobe  = phase2 & ~dir_out;
  assign rf_we        = read_strobe;
  assign rf_wdata     = in_port;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !busy && !read_strobe && !write_strobe); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy && !read_strobe && !write_strobe); // R2
  AST_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst) $rose(busy) |=> busy); // R2
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst) (read_strobe || write_strobe) |-> $stable(port_id) && $stable(out_port)); // R3
  AST_WSTB_PULSE: assert property (@(posedge clk) disable iff (rst) write_strobe |=> !write_strobe && !busy); // R4
  AST_RSTB_PULSE: assert property (@(posedge clk) disable iff (rst) read_strobe |=> !read_strobe && !busy); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(read_strobe && write_strobe)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(port_id) && $stable(out_port)); // R7
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst) (read_strobe || write_strobe) |-> busy); // R7

endmodule

// File: tb/tb_io_bus_sequencer.sv
module tb_io_bus_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, is_output = 0, addr_from_reg = 0;
  logic [7:0] imm_addr = 0, reg_addr = 0, src_data = 0, in_port = 0;
  logic [3:0] dst_idx = 0;
  logic [7:0] port_id, out_port, rf_wdata;
  logic [3:0] rf_widx;
  logic read_strobe, write_strobe, busy, rf_we;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  io_bus_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .is_output(is_output),
    .addr_from_reg(addr_from_reg), .imm_addr(imm_addr), .reg_addr(reg_addr),
    .src_data(src_data), .dst_idx(dst_idx), .in_port(in_port),
    .port_id(port_id), .out_port(out_port), .read_strobe(read_strobe),
    .write_strobe(write_strobe), .busy(busy), .rf_we(rf_we),
    .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus state {busy, rstb, wstb, rf_we}
  function automatic logic [3:0] ctl();
    return {busy, read_strobe, write_strobe, rf_we};
  endfunction

  task automatic transfer(input logic dir, input logic sel, input logic [7:0] ia,
                          input logic [7:0] ra, input logic [7:0] sd,
                          input logic [3:0] di, input logic [7:0] ip,
                          input logic hammer);
    logic [7:0] addr, prev_out;
    addr = sel ? ra : ia;
    prev_out = out_port;
    @(negedge clk);
    start = 1; is_output = dir; addr_from_reg = sel; imm_addr = ia;
    reg_addr = ra; src_data = sd; dst_idx = di; in_port = ip;
    @(negedge clk);
    if (hammer) begin
      is_output = ~dir; imm_addr = ~ia; reg_addr = ~ra; src_data = ~sd; dst_idx = ~di;
    end else start = 0;
    chk("R2 cycle1 ctl", ctl(), 4'b1000);
    chk("R2 cycle1 port_id", port_id, addr);
    chk(dir ? "R3 cycle1 out_port" : "R7 input keeps out_port", out_port, dir ? sd : prev_out);
    @(negedge clk);
    chk(dir ? "R4 cycle2 ctl" : "R5 cycle2 ctl", ctl(), dir ? 4'b1010 : 4'b1101);
    chk("R2 cycle2 port_id", port_id, addr);
    chk(dir ? "R3 cycle2 out_port" : "R7 input keeps out_port", out_port, dir ? sd : prev_out);
    if (!dir) begin
      chk("R5 rf_wdata", rf_wdata, ip);
      chk("R5 rf_widx", rf_widx, di);
    end
    if (hammer) chk("R6 rf_widx while busy", rf_widx, di);
    @(negedge clk);
    start = 0;
    chk(hammer ? "R6 ended on time" : "R7 idle ctl", ctl(), 4'b0000);
    chk("R7 port_id held", port_id, addr);
    chk("R7 out_port held", out_port, dir ? sd : prev_out);
    @(negedge clk);
    chk("R7 idle after gap", ctl(), 4'b0000);
    chk("R7 port_id still held", port_id, addr);
  endtask

  task automatic reset_check();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 ctl in reset", ctl(), 4'b0000);
    chk("R1 port_id", port_id, 8'h00);
    chk("R1 out_port", out_port, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 ctl after release", ctl(), 4'b0000);
  endtask

  initial begin
    fork
      begin
        reset_check();
        transfer(1, 0, 8'h5A, 8'h00, 8'hC3, 4'h0, 8'h00, 0);   // R3 R4 immediate
        transfer(0, 1, 8'h11, 8'h9E, 8'h00, 4'hF, 8'hA5, 0);   // R5 register addr
        transfer(1, 1, 8'h00, 8'hFF, 8'hFF, 4'h3, 8'h00, 0);   // R8 top address
        transfer(0, 0, 8'h00, 8'h77, 8'h12, 4'h0, 8'h00, 0);   // R8 bottom address
        transfer(0, 0, 8'hFF, 8'h00, 8'h00, 4'h7, 8'hFF, 0);   // R8 input at 0xFF
        transfer(1, 0, 8'h3C, 8'hC3, 8'h00, 4'h2, 8'h00, 0);   // R3 zero data
        transfer(1, 0, 8'h42, 8'h24, 8'h81, 4'h5, 8'h00, 1);   // R6 output hammered
        transfer(0, 1, 8'h0F, 8'hE1, 8'h66, 4'hA, 8'h5C, 1);   // R6 input hammered
        reset_check();                                        // R1 again after traffic
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule